// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block makes the 16x oversampling clock-enable for a UART receiver and transmitter. A reference clock is first thinned by a small integer pre-divider, selected through a 3-bit code. The divided-reference pulses then drive a fractional rate multiplier: each pulse adds an increment of (INC+1) to an accumulator. Whenever the accumulator reaches (MOD+1), that amount is taken away and a single-cycle tick is issued. The tick rate relative to the divided reference is therefore (INC+1)/(MOD+1).

Software programs three words through a plain write strobe: the increment, the modulus and a control word that holds the pre-divider code at bits 9:7. All three can be read back through a registered read strobe. For example, with a 16 MHz divided reference, MOD = 9999 and INC = baud/100 - 1 give the tick for the requested baud; at 115200 baud, INC is 1151. Any configuration write restarts the rate from a clean state. The tick stops while the enable input is low.

Top module: `frac_baud_gen`

## Requirements
- R1: With INC not above MOD, and with the accumulator starting from zero, the number of ticks after S divided-reference cycles is floor(S*(INC+1)/(MOD+1)). Each tick lasts one clock and appears one clock after the divided-reference cycle that produced it.
- R2: When INC is greater than MOD, a tick is issued on every divided-reference cycle.
- R3: Pre-divider codes 0 to 5 divide the reference by (6 - code): code 0 gives divide-by-6, code 3 gives divide-by-3 and code 5 gives divide-by-1. The first divided-reference cycle after a configuration write is the (6 - code)-th clock.
- R4: Pre-divider code 6 divides the reference by 7.
- R5: Pre-divider code 7 is reserved and divides by 1.
- R6: In the control word (address 2), only bits 9:7 hold the pre-divider code. All other bits are ignored on write and read back as zero.
- R7: A write to address 0 (INC), 1 (MOD) or 2 (control) clears the accumulator and the pre-divider counter in the same clock. Counting then restarts from zero.
- R8: While enable is low, no tick is produced in the following clock, and the accumulator and pre-divider counter hold their values. Counting resumes from those values when enable returns high.
- R9: A read strobe returns the addressed word on rd_data one clock later, and rd_data holds its value otherwise. Address 3 reads as zero, and writes to address 3 change nothing.
- R10: After reset, tick is low, INC and MOD are zero, and the pre-divider code is 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Allows the generator to advance and tick |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 INC, 1 MOD, 2 control, 3 unmapped |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address, same map as writes |
| rd_data | output | DATA_W | Registered read data |
| tick | output | 1 | One-clock pulse at 16x the baud rate |

## Verification
The bench builds the block with its default 16-bit INC and MOD and 16-bit data word. It programs small INC and MOD values, so that many complete accumulator wrap cycles fit in a few hundred clocks, and it also runs the realistic 115200-baud setting. Because every pre-divider code gives a period of at most seven clocks, all eight codes can be swept quickly. Exact first-tick positions can then be counted from the write edge. Tick counts over a window of cycles are compared with the floor formula, and this shows whether the accumulator keeps or loses its remainder across a disable or a rewrite.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [1:0] {
    SEL_INC  = 2'd0,
    SEL_MOD  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Pre-divider code to division ratio.
  function automatic logic [CODE_W-1:0] code_to_ratio(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] r;
    case (code)
      3'd6:    r = 3'd7;
      3'd7:    r = 3'd1;
      default: r = 3'd6 - code;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/frac_baud_regs.sv
module frac_baud_regs
  import frac_baud_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter int DATA_W = 16,
  parameter int CODE_LSB = 7,
  parameter logic [CODE_W-1:0] RST_CODE = 3'd5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [RATE_W-1:0] inc_q,
  output logic [RATE_W-1:0] mod_q,
  output logic [CODE_W-1:0] code_q,
  output logic              cfg_wr
);

  reg_sel_e wsel, rsel;
  logic [DATA_W-1:0] rd_word;

  assign wsel   = reg_sel_e'(wr_addr);
  assign rsel   = reg_sel_e'(rd_addr);
  assign cfg_wr = wr_en && (wsel != SEL_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      inc_q  <= '0;
      mod_q  <= '0;
      code_q <= RST_CODE;
    end else if (wr_en) begin
      case (wsel)
        SEL_INC:  inc_q  <= wr_data[RATE_W-1:0];
        SEL_MOD:  mod_q  <= wr_data[RATE_W-1:0];
        SEL_CTRL: code_q <= wr_data[CODE_LSB +: CODE_W];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rd_word = '0;
    case (rsel)
      SEL_INC:  rd_word[RATE_W-1:0]       = inc_q;
      SEL_MOD:  rd_word[RATE_W-1:0]       = mod_q;
      SEL_CTRL: rd_word[CODE_LSB +: CODE_W] = code_q;
      default:  rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rd_en) rd_data <= rd_word;
  end

endmodule

// File: rtl/frac_baud_prediv.sv
module frac_baud_prediv
  import frac_baud_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              enable,
  input  logic [CODE_W-1:0] code,
  output logic              strobe,
  output logic [CODE_W-1:0] cnt_o,
  output logic [CODE_W-1:0] ratio_o
);

  logic [CODE_W-1:0] cnt_q;
  logic [CODE_W-1:0] ratio;
  logic              last;

  assign ratio   = code_to_ratio(code);
  assign last    = (cnt_q == ratio - 3'd1);
  assign strobe  = enable && last;
  assign cnt_o   = cnt_q;
  assign ratio_o = ratio;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (enable) cnt_q <= last ? '0 : cnt_q + 3'd1;
  end

endmodule

// File: rtl/frac_baud_accum.sv
module frac_baud_accum #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              strobe,
  input  logic [RATE_W-1:0] inc,
  input  logic [RATE_W-1:0] modv,
  output logic              tick,
  output logic [RATE_W-1:0] acc_o
);

  localparam int SUM_W = RATE_W + 1;

  logic [RATE_W-1:0] acc_q;
  logic [SUM_W-1:0]  step, span, sum, rem;
  logic              wrap, saturate;

  assign step     = {1'b0, inc} + 1'b1;
  assign span     = {1'b0, modv} + 1'b1;
  assign sum      = {1'b0, acc_q} + step;
  assign rem      = sum - span;
  assign wrap     = (sum >= span);
  assign saturate = (inc > modv);
  assign acc_o    = acc_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (strobe) begin
        if (saturate) begin
          acc_q <= '0;
          tick  <= 1'b1;
        end else if (wrap) begin
          acc_q <= rem[RATE_W-1:0];
          tick  <= 1'b1;
        end else begin
          acc_q <= sum[RATE_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import frac_baud_pkg::*;
#(
  parameter int RATE_W = 16,
  parameter int DATA_W = 16,
  parameter int CODE_LSB = 7,
  parameter logic [CODE_W-1:0] RST_CODE = 3'd5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              tick
);

  logic [RATE_W-1:0] inc_q, mod_q, acc_q;
  logic [CODE_W-1:0] code_q, pdiv_cnt, pdiv_ratio;
  logic              cfg_wr, ref_strobe;

  frac_baud_regs #(
    .RATE_W(RATE_W), .DATA_W(DATA_W), .CODE_LSB(CODE_LSB), .RST_CODE(RST_CODE)
  ) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .inc_q(inc_q), .mod_q(mod_q), .code_q(code_q), .cfg_wr(cfg_wr)
  );

  frac_baud_prediv u_prediv (
    .clk(clk), .rst(rst), .clr(cfg_wr), .enable(enable), .code(code_q),
    .strobe(ref_strobe), .cnt_o(pdiv_cnt), .ratio_o(pdiv_ratio)
  );

  frac_baud_accum #(.RATE_W(RATE_W)) u_accum (
    .clk(clk), .rst(rst), .clr(cfg_wr), .strobe(ref_strobe),
    .inc(inc_q), .modv(mod_q), .tick(tick), .acc_o(acc_q)
  );

endmodule

// File: rtl/frac_baud_gen_checker.sv
module frac_baud_gen_checker
  import frac_baud_pkg::*;
#(
  parameter int RATE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              enable,
  input logic              tick,
  input logic              cfg_wr,
  input logic [RATE_W-1:0] acc,
  input logic [RATE_W-1:0] mod_q,
  input logic [CODE_W-1:0] cnt,
  input logic [CODE_W-1:0] ratio
);

  a_r8_no_tick_when_disabled: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !tick);

  a_r7_write_restarts: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> !tick);

  a_r1_acc_below_span: assert property (@(posedge clk) disable iff (rst)
    acc <= mod_q);

  a_r3_cnt_below_ratio: assert property (@(posedge clk) disable iff (rst)
    cnt < ratio);

  a_r1_single_cycle_tick: assert property (@(posedge clk) disable iff (rst)
    (tick && ratio > 3'd1) |=> !tick);

endmodule

bind frac_baud_gen frac_baud_gen_checker #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .tick(tick), .cfg_wr(cfg_wr),
  .acc(acc_q), .mod_q(mod_q), .cnt(pdiv_cnt), .ratio(pdiv_ratio)
);

// File: tb/frac_baud_gen_test.sv
module frac_baud_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  frac_baud_gen uut (
    .clk(clk), .rst(rst), .enable(enable),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    v = int'(rd_data);
  endtask

  task automatic setup(input int code, input int inc, input int modv);
    wr(2'd0, 16'(inc));
    wr(2'd1, 16'(modv));
    wr(2'd2, 16'hF000 | 16'(code << 7) | 16'h007F);
  endtask

  task automatic count_ticks(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (tick) c++;
    end
  endtask

  task automatic t_reset();
    int v;
    chk("R10 tick after reset", int'(tick), 0);
    rd(2'd0, v); chk("R10 INC reset", v, 0);
    rd(2'd1, v); chk("R10 MOD reset", v, 0);
    rd(2'd2, v); chk("R10 code reset", v, 5 << 7);
  endtask

  task automatic t_readback();
    int v;
    setup(3, 1234, 4321);
    rd(2'd0, v); chk("R9 INC readback", v, 1234);
    rd(2'd1, v); chk("R9 MOD readback", v, 4321);
    rd(2'd2, v); chk("R6 control only bits 9:7", v, 3 << 7);
    wr(2'd3, 16'hFFFF);
    rd(2'd0, v); chk("R9 unmapped write leaves INC", v, 1234);
    rd(2'd1, v); chk("R9 unmapped write leaves MOD", v, 4321);
    rd(2'd2, v); chk("R9 unmapped write leaves code", v, 3 << 7);
    rd(2'd3, v); chk("R9 unmapped reads zero", v, 0);
    count_ticks(3, v);
    chk("R9 rd_data holds without strobe", int'(rd_data), 0);
  endtask

  task automatic t_baud();
    int c;
    setup(5, 1151, 9999);
    count_ticks(2000, c);
    chk("R1 115200 setting tick count", c, 230);
  endtask

  task automatic t_first_tick();
    int c;
    setup(5, 0, 2);
    count_ticks(2, c); chk("R1 no tick before third cycle", c, 0);
    count_ticks(1, c); chk("R1 tick on third cycle", c, 1);
    count_ticks(27, c); chk("R1 ratio 1/3 count", c, 9);
    setup(5, 2, 6);
    count_ticks(70, c); chk("R1 ratio 3/7 count", c, 30);
  endtask

  task automatic t_wide();
    int c;
    setup(5, 5, 2);
    count_ticks(40, c); chk("R2 INC above MOD ticks every cycle", c, 40);
  endtask

  task automatic t_codes();
    int c;
    setup(0, 0, 0);
    count_ticks(5, c); chk("R3 code 0 no tick before sixth", c, 0);
    count_ticks(1, c); chk("R3 code 0 tick on sixth", c, 1);
    count_ticks(60, c); chk("R3 code 0 divide by 6", c, 10);
    setup(3, 0, 0);
    count_ticks(30, c); chk("R3 code 3 divide by 3", c, 10);
    setup(6, 0, 0);
    count_ticks(70, c); chk("R4 code 6 divide by 7", c, 10);
    setup(7, 0, 0);
    count_ticks(20, c); chk("R5 code 7 divide by 1", c, 20);
  endtask

  task automatic t_clear();
    int c;
    setup(5, 0, 4);
    count_ticks(3, c); chk("R7 partial run", c, 0);
    wr(2'd1, 16'd4);
    count_ticks(4, c); chk("R7 write restarts accumulator", c, 0);
    count_ticks(1, c); chk("R7 first tick after restart", c, 1);
    setup(0, 0, 0);
    count_ticks(2, c);
    wr(2'd0, 16'd0);
    count_ticks(5, c); chk("R7 write restarts pre-divider", c, 0);
    count_ticks(1, c); chk("R7 pre-divider tick after restart", c, 1);
  endtask

  task automatic t_enable();
    int c;
    setup(5, 0, 3);
    count_ticks(6, c); chk("R8 enabled phase", c, 1);
    enable = 1'b0;
    count_ticks(20, c); chk("R8 no tick while disabled", c, 0);
    enable = 1'b1;
    count_ticks(10, c); chk("R8 accumulator held over disable", c, 3);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_readback();
    t_baud();
    t_first_tick();
    t_wide();
    t_codes();
    t_clear();
    t_enable();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule